// File: doc/BRIEF.md
# Character-Row Video Sync Timing Generator

This block produces the raster timing for a character-based display. A horizontal character counter runs from 0 to a programmed total and then wraps. Each wrap ends one scanline. A scanline counter groups lines into character rows, and a row counter groups rows into a frame. From these counters the block drives a horizontal sync pulse, a vertical sync pulse, a display-enable window and a memory address for the character fetch.

A byte-wide write port loads eight timing registers. Every comparison uses the live register value, so a write changes the timing on the next clock. The counters hold no shadow copies. The one buffered value is the line-start address. The address counter reloads from it at the start of every scanline, and it moves forward by one displayed row width at the end of each character row.

A variant-select input picks among several historical controller behaviours. The variants differ in how a zero horizontal sync width is treated and in whether the vertical sync width can be programmed at all.

Top module: `crt_timing_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `hsync`, `vsync` and `de` are 0 and `ma` is 0. Reset loads the package default register values.
- R2: The horizontal counter counts 0, 1, … up to horizontal total (register select 0) and then returns to 0. One scanline is therefore total+1 clocks. Each wrap advances the scanline counter. After the scanline whose index equals the last-scanline register (select 7, 5 bits), the scanline counter returns to 0 and the row counter advances. After the row equal to vertical total, the row counter returns to 0.
- R3: `hsync` is high starting in the cycle in which the horizontal counter equals the sync position (select 2). It stays high for W clocks, where W is bits [3:0] of the sync width register (select 3).
- R4: If bits [3:0] of select 3 are 0, variant codes 0 and 1 produce no `hsync` at all, and variant codes 2 and above produce a 16-clock `hsync`.
- R5: `vsync` goes high at horizontal count 0 of scanline 0 of the row whose index equals the vertical sync position (select 6). It lasts N whole scanlines, where N is bits [7:4] of select 3, and a value of 0 gives 16.
- R6: With variant code 1 or 2, bits [7:4] of select 3 are ignored and `vsync` always lasts 16 scanlines.
- R7: `de` is high exactly while the horizontal counter is below horizontal displayed (select 1) and the row counter is below vertical displayed (select 5).
- R8: If vertical displayed is 0, `de` stays low for the whole frame.
- R9: `ma` increases by 1 every clock within a scanline and reloads the saved line-start address at every scanline start. At the end of a character row the line-start address grows by horizontal displayed. At the end of a frame both the line-start address and `ma` return to 0.
- R10: A register write changes the output timing from the next clock on. No value is held back until a line or frame boundary.
- R11: Vertical total (select 4), vertical displayed and vertical sync position are 7 bits wide; bit 7 of the written byte is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select (0..7; others ignored) |
| wr_data | input | 8 | Register write data |
| variant | input | 3 | Controller variant code |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Display enable |
| ma | output | MA_W | Character memory address |

## Verification
The hardest condition to reach is a register write that lands in the middle of a sync pulse or a row. Examples are a width nibble changed while `hsync` is high, or a variant change during `vsync`. These cases test the rule that every counter compares against live values. The bench reaches them with a long random phase in which seeded writes to position, width and displayed registers, along with variant changes, arrive at irregular intervals. A cycle-accurate reference model built from the requirements is compared against every output on every clock. Directed phases first pin down the zero-width encodings, the fixed 16-line variants, zero displayed rows and the masked top bit of vertical total.

// File: rtl/crtg_pkg.sv
package crtg_pkg;
  localparam int H_W = 8;
  localparam int V_W = 7;
  localparam int S_W = 5;

  typedef enum logic [3:0] {
    SEL_HTOT  = 4'd0,
    SEL_HDISP = 4'd1,
    SEL_HSPOS = 4'd2,
    SEL_SYNCW = 4'd3,
    SEL_VTOT  = 4'd4,
    SEL_VDISP = 4'd5,
    SEL_VSPOS = 4'd6,
    SEL_LASTS = 4'd7
  } reg_sel_e;

  typedef struct packed {
    logic [H_W-1:0] htot;
    logic [H_W-1:0] hdisp;
    logic [H_W-1:0] hspos;
    logic [7:0]     syncw;
    logic [V_W-1:0] vtot;
    logic [V_W-1:0] vdisp;
    logic [V_W-1:0] vspos;
    logic [S_W-1:0] lasts;
  } timing_regs_t;

  localparam logic [H_W-1:0] DEF_HTOT  = 8'd63;
  localparam logic [H_W-1:0] DEF_HDISP = 8'd40;
  localparam logic [H_W-1:0] DEF_HSPOS = 8'd46;
  localparam logic [7:0]     DEF_SYNCW = 8'h8E;
  localparam logic [V_W-1:0] DEF_VTOT  = 7'd38;
  localparam logic [V_W-1:0] DEF_VDISP = 7'd25;
  localparam logic [V_W-1:0] DEF_VSPOS = 7'd30;
  localparam logic [S_W-1:0] DEF_LASTS = 5'd7;
endpackage

// File: rtl/crtg_regs.sv
module crtg_regs
  import crtg_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [3:0]   wr_sel,
  input  logic [7:0]   wr_data,
  output timing_regs_t regs
);
  always_ff @(posedge clk) begin
    if (rst) begin
      regs.htot  <= DEF_HTOT;
      regs.hdisp <= DEF_HDISP;
      regs.hspos <= DEF_HSPOS;
      regs.syncw <= DEF_SYNCW;
      regs.vtot  <= DEF_VTOT;
      regs.vdisp <= DEF_VDISP;
      regs.vspos <= DEF_VSPOS;
      regs.lasts <= DEF_LASTS;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_HTOT:  regs.htot  <= wr_data[H_W-1:0];
        SEL_HDISP: regs.hdisp <= wr_data[H_W-1:0];
        SEL_HSPOS: regs.hspos <= wr_data[H_W-1:0];
        SEL_SYNCW: regs.syncw <= wr_data;
        SEL_VTOT:  regs.vtot  <= wr_data[V_W-1:0];
        SEL_VDISP: regs.vdisp <= wr_data[V_W-1:0];
        SEL_VSPOS: regs.vspos <= wr_data[V_W-1:0];
        SEL_LASTS: regs.lasts <= wr_data[S_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/crtg_horiz.sv
module crtg_horiz #(
  parameter int H_W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [H_W-1:0] htot,
  input  logic [H_W-1:0] hspos,
  input  logic [3:0]     hnib,
  input  logic           zero_is_16,
  output logic [H_W-1:0] hcc,
  output logic [H_W-1:0] hcc_n,
  output logic           line_end,
  output logic           hsync
);
  logic [4:0] hsc;
  logic [4:0] hwidth;

  always_comb begin
    if (hnib != 4'd0)    hwidth = {1'b0, hnib};
    else if (zero_is_16) hwidth = 5'd16;
    else                 hwidth = 5'd0;
  end

  assign line_end = (hcc == htot);
  assign hcc_n    = line_end ? '0 : hcc + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcc   <= '0;
      hsc   <= '0;
      hsync <= 1'b0;
    end else begin
      hcc <= hcc_n;
      if (hsync) begin
        if (hsc == hwidth) hsync <= 1'b0;
        else               hsc   <= hsc + 1'b1;
      end else if (hcc_n == hspos && hwidth != 5'd0) begin
        hsync <= 1'b1;
        hsc   <= 5'd1;
      end
    end
  end
endmodule

// File: rtl/crtg_vert.sv
module crtg_vert #(
  parameter int V_W = 7,
  parameter int S_W = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           line_end,
  input  logic [V_W-1:0] vtot,
  input  logic [V_W-1:0] vspos,
  input  logic [S_W-1:0] lasts,
  input  logic [3:0]     vnib,
  input  logic           fixed_16,
  output logic [V_W-1:0] vcc_n,
  output logic           row_end,
  output logic           frame_end,
  output logic           vsync
);
  logic [V_W-1:0] vcc;
  logic [S_W-1:0] rc;
  logic [4:0]     vsc;
  logic [4:0]     vwidth;

  assign vwidth    = (fixed_16 || vnib == 4'd0) ? 5'd16 : {1'b0, vnib};
  assign row_end   = (rc == lasts);
  assign frame_end = row_end && (vcc == vtot);
  assign vcc_n     = (line_end && row_end) ? (frame_end ? '0 : vcc + 1'b1) : vcc;

  always_ff @(posedge clk) begin
    if (rst) begin
      rc    <= '0;
      vcc   <= '0;
      vsc   <= '0;
      vsync <= 1'b0;
    end else if (line_end) begin
      rc  <= row_end ? '0 : rc + 1'b1;
      vcc <= vcc_n;
      if (vsync) begin
        if (vsc == vwidth) vsync <= 1'b0;
        else               vsc   <= vsc + 1'b1;
      end else if (row_end && vcc_n == vspos) begin
        vsync <= 1'b1;
        vsc   <= 5'd1;
      end
    end
  end
endmodule

// File: rtl/crtg_addr.sv
module crtg_addr #(
  parameter int MA_W = 14,
  parameter int H_W  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            line_end,
  input  logic            row_end,
  input  logic            frame_end,
  input  logic [H_W-1:0]  hdisp,
  output logic [MA_W-1:0] ma
);
  logic [MA_W-1:0] line_base;
  logic [MA_W-1:0] next_base;

  assign next_base = line_base + MA_W'(hdisp);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_base <= '0;
      ma        <= '0;
    end else if (line_end) begin
      if (frame_end) begin
        line_base <= '0;
        ma        <= '0;
      end else if (row_end) begin
        line_base <= next_base;
        ma        <= next_base;
      end else begin
        ma <= line_base;
      end
    end else begin
      ma <= ma + 1'b1;
    end
  end
endmodule

// File: rtl/crt_timing_gen.sv
module crt_timing_gen
  import crtg_pkg::*;
#(
  parameter int MA_W = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [3:0]      wr_sel,
  input  logic [7:0]      wr_data,
  input  logic [2:0]      variant,
  output logic            hsync,
  output logic            vsync,
  output logic            de,
  output logic [MA_W-1:0] ma
);
  timing_regs_t   regs;
  logic [H_W-1:0] hcc_q;
  logic [H_W-1:0] hcc_n;
  logic [V_W-1:0] vcc_n;
  logic           line_end;
  logic           row_end;
  logic           frame_end;
  logic           zero_is_16;
  logic           fixed_16;
  logic [H_W-1:0] hdisp_w;
  logic [V_W-1:0] vdisp_w;
  logic [3:0]     hnib_w;

  assign zero_is_16 = (variant >= 3'd2);
  assign fixed_16   = (variant == 3'd1) || (variant == 3'd2);
  assign hdisp_w    = regs.hdisp;
  assign vdisp_w    = regs.vdisp;
  assign hnib_w     = regs.syncw[3:0];

  crtg_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .regs(regs)
  );

  crtg_horiz #(.H_W(H_W)) u_horiz (
    .clk(clk), .rst(rst), .htot(regs.htot), .hspos(regs.hspos),
    .hnib(hnib_w), .zero_is_16(zero_is_16), .hcc(hcc_q),
    .hcc_n(hcc_n), .line_end(line_end), .hsync(hsync)
  );

  crtg_vert #(.V_W(V_W), .S_W(S_W)) u_vert (
    .clk(clk), .rst(rst), .line_end(line_end), .vtot(regs.vtot),
    .vspos(regs.vspos), .lasts(regs.lasts), .vnib(regs.syncw[7:4]),
    .fixed_16(fixed_16), .vcc_n(vcc_n), .row_end(row_end),
    .frame_end(frame_end), .vsync(vsync)
  );

  crtg_addr #(.MA_W(MA_W), .H_W(H_W)) u_addr (
    .clk(clk), .rst(rst), .line_end(line_end), .row_end(row_end),
    .frame_end(frame_end), .hdisp(regs.hdisp), .ma(ma)
  );

  always_ff @(posedge clk) begin
    if (rst) de <= 1'b0;
    else     de <= (hcc_n < regs.hdisp) && (vcc_n < regs.vdisp);
  end
endmodule

// File: rtl/crtg_checker.sv
module crtg_checker #(
  parameter int MA_W = 14,
  parameter int H_W  = 8,
  parameter int V_W  = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            hsync,
  input logic            vsync,
  input logic            de,
  input logic [MA_W-1:0] ma,
  input logic [2:0]      variant,
  input logic            line_end,
  input logic [H_W-1:0]  hcc,
  input logic [H_W-1:0]  hdisp,
  input logic [V_W-1:0]  vdisp,
  input logic [3:0]      hnib
);
  logic [5:0] vs_lines;
  logic       vs_fixed_all;
  logic       fixed_now;

  assign fixed_now = (variant == 3'd1) || (variant == 3'd2);

  always_ff @(posedge clk) begin
    if (rst || !vsync) begin
      vs_lines     <= '0;
      vs_fixed_all <= 1'b1;
    end else begin
      if (line_end) vs_lines <= vs_lines + 1'b1;
      vs_fixed_all <= vs_fixed_all & fixed_now;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!hsync && !vsync && !de && ma == '0)); // R1

  AST_HS_ZERO_NONE: assert property (@(posedge clk) disable iff (rst)
    (hnib == 4'd0 && variant < 3'd2 && !hsync) |=> !hsync); // R4

  AST_VS_FIXED_LEN: assert property (@(posedge clk) disable iff (rst)
    ($fell(vsync) && vs_fixed_all) |-> (vs_lines == 6'd16)); // R6

  AST_DE_HWINDOW: assert property (@(posedge clk) disable iff (rst)
    (de && $stable(hdisp)) |-> (hcc < hdisp)); // R7

  AST_DE_NO_ROWS: assert property (@(posedge clk) disable iff (rst)
    (vdisp == '0) |=> !de); // R8

  AST_MA_STEP: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> (ma == MA_W'($past(ma) + 1'b1))); // R9
endmodule

bind crt_timing_gen crtg_checker #(.MA_W(MA_W), .H_W(crtg_pkg::H_W), .V_W(crtg_pkg::V_W)) u_chk (
  .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .de(de), .ma(ma),
  .variant(variant), .line_end(line_end), .hcc(hcc_q), .hdisp(hdisp_w),
  .vdisp(vdisp_w), .hnib(hnib_w)
);

// File: tb/sim_crt_timing_gen.sv
`timescale 1ns/1ps
module sim_crt_timing_gen;
  import crtg_pkg::*;
  localparam int MA_W = 14;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic [3:0]      wr_sel = '0;
  logic [7:0]      wr_data = '0;
  logic [2:0]      variant = '0;
  logic            hsync, vsync, de;
  logic [MA_W-1:0] ma;

  always #5 clk = ~clk;

  crt_timing_gen #(.MA_W(MA_W)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .variant(variant), .hsync(hsync), .vsync(vsync), .de(de), .ma(ma)
  );

  int errors = 0;
  int checks = 0;
  string t_hs = "R3", t_vs = "R5", t_de = "R7", t_ma = "R9";

  // reference model mirrors (written from the requirements)
  logic [7:0] b_htot, b_hdisp, b_hpos, b_sync;
  logic [6:0] b_vtot, b_vdisp, b_vpos;
  logic [4:0] b_last;
  logic [7:0] m_h, nh;
  logic [4:0] m_r, nr;
  logic [6:0] m_v, nv;
  logic [4:0] m_hc, m_vc, hw, vw;
  logic       m_hs, m_vs, m_de, le, eor, eof;
  logic [MA_W-1:0] m_ma, m_base;

  function automatic logic [4:0] want_hw(logic [3:0] n, logic [2:0] v);
    if (n != 0) return {1'b0, n};
    return (v >= 3'd2) ? 5'd16 : 5'd0;
  endfunction

  function automatic logic [4:0] want_vw(logic [3:0] n, logic [2:0] v);
    if (v == 3'd1 || v == 3'd2 || n == 0) return 5'd16;
    return {1'b0, n};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      b_htot = DEF_HTOT; b_hdisp = DEF_HDISP; b_hpos = DEF_HSPOS; b_sync = DEF_SYNCW;
      b_vtot = DEF_VTOT; b_vdisp = DEF_VDISP; b_vpos = DEF_VSPOS; b_last = DEF_LASTS;
      m_h = 0; m_r = 0; m_v = 0; m_hc = 0; m_vc = 0;
      m_hs = 0; m_vs = 0; m_de = 0; m_ma = 0; m_base = 0;
    end else begin
      le  = (m_h == b_htot);
      eor = (m_r == b_last);
      eof = eor && (m_v == b_vtot);
      nh  = le ? 8'd0 : m_h + 8'd1;
      nr  = le ? (eor ? 5'd0 : m_r + 5'd1) : m_r;
      nv  = (le && eor) ? (eof ? 7'd0 : m_v + 7'd1) : m_v;
      hw  = want_hw(b_sync[3:0], variant);
      vw  = want_vw(b_sync[7:4], variant);
      if (m_hs) begin
        if (m_hc == hw) m_hs = 0; else m_hc = m_hc + 5'd1;
      end else if (nh == b_hpos && hw != 0) begin
        m_hs = 1; m_hc = 5'd1;
      end
      if (le) begin
        if (m_vs) begin
          if (m_vc == vw) m_vs = 0; else m_vc = m_vc + 5'd1;
        end else if (eor && nv == b_vpos) begin
          m_vs = 1; m_vc = 5'd1;
        end
        if (eof) begin m_base = 0; m_ma = 0; end
        else if (eor) begin m_base = m_base + MA_W'(b_hdisp); m_ma = m_base; end
        else m_ma = m_base;
      end else begin
        m_ma = m_ma + 1'b1;
      end
      m_de = (nh < b_hdisp) && (nv < b_vdisp);
      m_h = nh; m_r = nr; m_v = nv;
      if (wr_en) begin
        case (wr_sel)
          4'd0: b_htot  = wr_data;
          4'd1: b_hdisp = wr_data;
          4'd2: b_hpos  = wr_data;
          4'd3: b_sync  = wr_data;
          4'd4: b_vtot  = wr_data[6:0];
          4'd5: b_vdisp = wr_data[6:0];
          4'd6: b_vpos  = wr_data[6:0];
          4'd7: b_last  = wr_data[4:0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual=%0d expected=%0d", tag, what, $time, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (rst) begin
      chk("R1", "hsync", hsync, 0); chk("R1", "vsync", vsync, 0);
      chk("R1", "de", de, 0);       chk("R1", "ma", ma, 0);
    end else begin
      chk(t_hs, "hsync", hsync, m_hs); chk(t_vs, "vsync", vsync, m_vs);
      chk(t_de, "de", de, m_de);       chk(t_ma, "ma", ma, m_ma);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic setup(input logic [2:0] v, input logic [7:0] ht, hd, hp, sw,
                       input logic [7:0] vt, vd, vp, ls);
    rst = 1; tick(); tick(); tick();
    rst = 0; variant = v;
    t_hs = "R10"; t_vs = "R10"; t_de = "R10"; t_ma = "R10";
    wr(4'd0, ht); wr(4'd1, hd); wr(4'd2, hp); wr(4'd3, sw);
    wr(4'd4, vt); wr(4'd5, vd); wr(4'd6, vp); wr(4'd7, ls);
  endtask

  task automatic run(int n, string a, string b, string c, string d);
    t_hs = a; t_vs = b; t_de = c; t_ma = d;
    repeat (n) tick();
  endtask

  initial begin
    #(1_500_000ns);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
    // R1 reset state, R2/R3/R5/R7/R9 basic frame
    setup(3'd0, 8'd9, 8'd6, 8'd7, 8'h32, 8'd4, 8'd3, 8'd3, 8'd1);
    run(300, "R3", "R5", "R7", "R9");
    // R2 different totals and scanline count
    setup(3'd4, 8'd13, 8'd10, 8'd2, 8'h25, 8'd3, 8'd2, 8'd1, 8'd2);
    run(300, "R2", "R5", "R7", "R2");
    // R4 zero horizontal width: none on variant 0/1, 16 on 2+
    setup(3'd0, 8'd19, 8'd8, 8'd3, 8'h20, 8'd3, 8'd2, 8'd1, 8'd0);
    run(200, "R4", "R5", "R7", "R9");
    variant = 3'd1; run(100, "R4", "R5", "R7", "R9");
    setup(3'd3, 8'd19, 8'd8, 8'd3, 8'h20, 8'd3, 8'd2, 8'd1, 8'd0);
    run(200, "R4", "R5", "R7", "R9");
    // R5 zero vertical width gives 16 lines
    setup(3'd0, 8'd7, 8'd4, 8'd5, 8'h03, 8'd23, 8'd10, 8'd2, 8'd0);
    run(450, "R3", "R5", "R7", "R9");
    // R6 fixed 16 lines on variants 1 and 2
    setup(3'd1, 8'd7, 8'd4, 8'd5, 8'h33, 8'd23, 8'd10, 8'd2, 8'd0);
    run(450, "R3", "R6", "R7", "R9");
    setup(3'd2, 8'd7, 8'd4, 8'd5, 8'h53, 8'd23, 8'd10, 8'd2, 8'd0);
    run(450, "R3", "R6", "R7", "R9");
    // R8 zero displayed rows
    setup(3'd0, 8'd9, 8'd6, 8'd7, 8'h32, 8'd4, 8'd0, 8'd3, 8'd1);
    run(250, "R3", "R5", "R8", "R9");
    // R11 top bit of vertical total ignored (0x85 -> 5)
    setup(3'd0, 8'd7, 8'd5, 8'd6, 8'h21, 8'h85, 8'd4, 8'd2, 8'd1);
    run(300, "R3", "R11", "R7", "R11");
    // R10 random live writes, including ignored selects
    setup(3'd0, 8'd15, 8'd10, 8'd12, 8'h42, 8'd9, 8'd6, 8'd7, 8'd2);
    for (int i = 0; i < 120; i++) begin
      int gap = 5 + int'($urandom % 40);
      run(gap, "R10", "R10", "R10", "R10");
      case ($urandom % 7)
        0: wr(4'd1, 8'($urandom % 18));
        1: wr(4'd2, 8'($urandom % 18));
        2: wr(4'd3, 8'($urandom));
        3: wr(4'd5, 8'($urandom % 12));
        4: wr(4'd6, 8'($urandom % 11));
        5: variant = 3'($urandom % 5);
        default: wr(4'(8 + $urandom % 8), 8'($urandom));
      endcase
    end
    run(200, "R10", "R10", "R10", "R10");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule